// File: doc/BRIEF.md
# Receive Character Queue with Error-Status Lock

This block buffers received characters on their way from a serial receiver to a processor or a DMA engine. Every character is stored together with four error flags. The exit slot of the queue is visible to both readers at all times, so software can inspect a character's flags before it takes the byte. A read by either reader removes the data and its flags in the same operation.

When locking is enabled, consuming a character that carries any error flag freezes the queue. The consumed character and its flags stay on the exit outputs and can be read again as often as needed. The DMA request is withheld, and nothing more leaves the queue until an error-reset pulse arrives. When locking is disabled, for example in an interrupt-per-character scheme, flagged characters pass through with no freeze.

Both modes send a one-cycle strobe to the interrupt logic whenever a flagged character is consumed. The block also reports whether the exit slot holds a character and how many characters are waiting.

Top module: `rxq_status_fifo`

## Requirements
- R1: While reset is asserted and after its release, `level` is 0 and `avail`, `locked`, `dma_req` and `spec_taken` are all 0.
- R2: Characters leave in the order they were written. `level` follows writes and removals, and its largest value is DEPTH.
- R3: A cycle with `cpu_rd`, `dma_rd` or both high removes exactly one entry when the queue is not empty and not locked. A read of an empty queue changes nothing.
- R4: When the queue is not locked, `head_data` and `head_stat` show the oldest entry and stay unchanged while no read occurs. `avail` is high exactly when `level` is non-zero.
- R5: A write into a full queue with no removal in the same cycle replaces the newest entry with the new byte. That entry's status is stored with the overrun bit (bit 1) set, and `level` stays at DEPTH. A write and a removal in the same cycle on a full queue store the entry normally.
- R6: The status bits are parity error (bit 0), overrun (bit 1), framing or CRC error (bit 2) and end-of-frame (bit 3), and an entry is special when any of them is set. With `lock_en` high, removing a special entry sets `locked` on the next cycle. From then on the exit outputs show that entry's data and status.
- R7: While `locked` is high, `cpu_rd` and `dma_rd` remove nothing, and `level` changes only through writes.
- R8: An `err_reset` pulse while locked clears `locked` on the next cycle, and the exit outputs return to the oldest queued entry. An `err_reset` while not locked has no effect.
- R9: With `lock_en` low, removing a special entry does not set `locked`.
- R10: `spec_taken` is high for exactly the one cycle after each removal of a special entry, in either mode.
- R11: `dma_req` is high exactly when the queue is not empty and not locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store a received character |
| wr_data | input | DATA_W | Received character |
| wr_stat | input | 4 | Error flags of the received character |
| cpu_rd | input | 1 | Processor data read |
| dma_rd | input | 1 | DMA data read |
| lock_en | input | 1 | 1: special character locks the queue; 0: no locking |
| err_reset | input | 1 | Releases the lock |
| head_data | output | DATA_W | Exit-slot data, or the held byte while locked |
| head_stat | output | 4 | Exit-slot flags, or the held flags while locked |
| avail | output | 1 | Exit slot occupied |
| level | output | $clog2(DEPTH+1) | Number of queued entries |
| dma_req | output | 1 | Character available to the DMA |
| locked | output | 1 | Queue frozen after a special character |
| spec_taken | output | 1 | One-cycle strobe after a special character is removed |

## Verification
A write and a removal can fall in the same cycle. This matters most on a full queue, where the write must be stored as a new entry and not overwrite the newest one with the overrun flag. It also matters when a write arrives in the cycle that a special character locks the queue or that `err_reset` releases it. The bench fills the queue to DEPTH and then drives a write together with a read, and the random phase keeps writes, reads and error resets overlapping. Each cycle the outputs are compared with a queue model in the bench that applies the removal first and the write second.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STAT_W     = 4;
  localparam int ST_PARITY  = 0;
  localparam int ST_OVERRUN = 1;
  localparam int ST_FRAME   = 2;
  localparam int ST_EOF     = 3;

  function automatic logic is_special(input logic [STAT_W-1:0] st);
    return |st;
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [ENT_W-1:0]           din,
  input  logic [ENT_W-1:0]           din_ovr,
  input  logic                       pop,
  output logic [ENT_W-1:0]           head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, rd_ptr_n, wr_ptr, wr_ptr_n, newest;
  logic [CW-1:0]    cnt, cnt_n;
  logic             full, do_push, do_over;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt == CW'(DEPTH));
    do_over  = push && full && !pop;
    do_push  = push && !do_over;
    newest   = (wr_ptr == '0) ? LAST : wr_ptr - 1'b1;
    rd_ptr_n = pop ? bump(rd_ptr) : rd_ptr;
    wr_ptr_n = do_push ? bump(wr_ptr) : wr_ptr;
    cnt_n    = cnt;
    case ({do_push, pop})
      2'b10:   cnt_n = cnt + 1'b1;
      2'b01:   cnt_n = cnt - 1'b1;
      default: cnt_n = cnt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      rd_ptr <= rd_ptr_n;
      wr_ptr <= wr_ptr_n;
      cnt    <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)      mem[wr_ptr] <= din;
    else if (do_over) mem[newest] <= din_ovr;
  end

  assign head  = mem[rd_ptr];
  assign count = cnt;

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt != '0));
  assert_full_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt == CW'(DEPTH)));
  assert_pop_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rxq_lock.sv
module rxq_lock
  import rxq_pkg::*;
#(
  parameter int ENT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic [ENT_W-1:0] head,
  input  logic             head_valid,
  input  logic             lock_en,
  input  logic             err_reset,
  output logic             pop,
  output logic             locked,
  output logic [ENT_W-1:0] held,
  output logic             spec_strobe
);
  logic             lock_q, lock_n, strobe_n, strobe_q, special, held_en;

  always_comb begin
    special  = is_special(head[ENT_W-1 -: STAT_W]);
    pop      = rd_req && head_valid && !lock_q;
    strobe_n = pop && special;
    held_en  = pop && special && lock_en;
    lock_n   = lock_q;
    if (held_en)                 lock_n = 1'b1;
    else if (err_reset && lock_q) lock_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      strobe_q <= 1'b0;
      held     <= '0;
    end else begin
      lock_q   <= lock_n;
      strobe_q <= strobe_n;
      if (held_en) held <= head;
    end
  end

  assign locked      = lock_q;
  assign spec_strobe = strobe_q;

  assert_lock_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(pop && special && lock_en));
  assert_held_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(held));
  assert_unlock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && err_reset) |=> !locked);
  assert_no_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_en && !locked) |=> !locked);
  assert_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && special) |=> spec_strobe);
endmodule

// File: rtl/rxq_status_fifo.sv
module rxq_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [3:0]                 wr_stat,
  input  logic                       cpu_rd,
  input  logic                       dma_rd,
  input  logic                       lock_en,
  input  logic                       err_reset,
  output logic [DATA_W-1:0]          head_data,
  output logic [3:0]                 head_stat,
  output logic                       avail,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       dma_req,
  output logic                       locked,
  output logic                       spec_taken
);
  localparam int ENT_W = DATA_W + STAT_W;

  logic [ENT_W-1:0] din, din_ovr, head, held, shown;
  logic             pop, head_valid;
  logic [$clog2(DEPTH+1)-1:0] count;

  always_comb begin
    din                     = {wr_stat, wr_data};
    din_ovr                 = din;
    din_ovr[DATA_W+ST_OVERRUN] = 1'b1;
    head_valid              = (count != '0);
    shown                   = locked ? held : head;
  end

  rxq_store #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .din(din), .din_ovr(din_ovr),
    .pop(pop), .head(head), .count(count)
  );

  rxq_lock #(.ENT_W(ENT_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .rd_req(cpu_rd || dma_rd), .head(head),
    .head_valid(head_valid), .lock_en(lock_en), .err_reset(err_reset),
    .pop(pop), .locked(locked), .held(held), .spec_strobe(spec_taken)
  );

  assign head_data = shown[DATA_W-1:0];
  assign head_stat = shown[ENT_W-1 -: STAT_W];
  assign avail     = head_valid;
  assign level     = count;
  assign dma_req   = head_valid && !locked;

  assert_dma_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (!locked && level != '0));
  assert_locked_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !wr_en) |=> (level == $past(level)));
endmodule

// File: tb/rxq_status_fifo_test.sv
module rxq_status_fifo_test;
  localparam int DEPTH = 8;

  logic       clk = 1'b0;
  logic       rst_n, wr_en, cpu_rd, dma_rd, lock_en, err_reset;
  logic [7:0] wr_data, head_data;
  logic [3:0] wr_stat, head_stat;
  logic [3:0] level;
  logic       avail, dma_req, locked, spec_taken;

  always #10 clk = ~clk;

  rxq_status_fifo #(.DEPTH(DEPTH), .DATA_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_stat(wr_stat),
    .cpu_rd(cpu_rd), .dma_rd(dma_rd), .lock_en(lock_en), .err_reset(err_reset),
    .head_data(head_data), .head_stat(head_stat), .avail(avail), .level(level),
    .dma_req(dma_req), .locked(locked), .spec_taken(spec_taken)
  );

  int checks = 0;
  int errors = 0;
  logic [11:0] q[$];
  logic        m_locked = 1'b0;
  logic [11:0] m_held = '0;
  logic        m_strobe = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_spec(input logic [11:0] e);
    return e[11:8] != 4'h0;
  endfunction

  task automatic idle();
    wr_en = 0; cpu_rd = 0; dma_rd = 0; err_reset = 0;
    wr_data = '0; wr_stat = '0;
  endtask

  task automatic compare_all();
    chk("R2 level", int'(level), q.size());
    chk("R4 avail", int'(avail), int'(q.size() > 0));
    chk("R11 dma_req", int'(dma_req), int'(q.size() > 0 && !m_locked));
    chk("R7 locked", int'(locked), int'(m_locked));
    chk("R10 spec_taken", int'(spec_taken), int'(m_strobe));
    if (m_locked) begin
      chk("R6 held data", int'(head_data), int'(m_held[7:0]));
      chk("R6 held stat", int'(head_stat), int'(m_held[11:8]));
    end else if (q.size() > 0) begin
      chk("R3 head data", int'(head_data), int'(q[0][7:0]));
      chk("R4 head stat", int'(head_stat), int'(q[0][11:8]));
    end
  endtask

  // one clock: model applies removal first, then the write
  task automatic cyc();
    logic do_pop;
    logic [11:0] e;
    do_pop = (cpu_rd || dma_rd) && q.size() > 0 && !m_locked;
    m_strobe = 1'b0;
    if (do_pop) begin
      e = q.pop_front();
      m_strobe = is_spec(e);
      if (is_spec(e) && lock_en) begin
        m_locked = 1'b1;
        m_held = e;
      end
    end else if (err_reset && m_locked) begin
      m_locked = 1'b0;
    end
    if (wr_en) begin
      if (q.size() < DEPTH) q.push_back({wr_stat, wr_data});
      else q[q.size()-1] = {wr_stat | 4'b0010, wr_data};
    end
    @(posedge clk);
    #2;
    compare_all();
    idle();
  endtask

  task automatic put(input logic [7:0] d, input logic [3:0] s);
    wr_en = 1; wr_data = d; wr_stat = s;
    cyc();
  endtask

  initial begin
    #(20 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7391));
    rst_n = 0; lock_en = 1; idle();
    repeat (3) @(posedge clk);
    #2;
    chk("R1 level in reset", int'(level), 0);
    chk("R1 locked in reset", int'(locked), 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #2;
    chk("R1 avail", int'(avail), 0);
    chk("R1 dma_req", int'(dma_req), 0);
    chk("R1 spec_taken", int'(spec_taken), 0);

    // read of empty queue: no effect
    cpu_rd = 1; cyc();
    chk("R3 empty read", int'(level), 0);

    // lock flow
    put(8'h11, 4'h0); put(8'h22, 4'h8); put(8'h33, 4'h0);
    cpu_rd = 1; cyc();
    chk("R3 pop one", int'(head_data), 8'h22);
    cyc(); cyc();
    chk("R4 status visible without pop", int'(head_stat), 4'h8);
    dma_rd = 1; cyc();
    chk("R6 lock set", int'(locked), 1);
    chk("R6 held byte", int'(head_data), 8'h22);
    chk("R10 strobe", int'(spec_taken), 1);
    cyc();
    chk("R10 strobe one cycle", int'(spec_taken), 0);
    cpu_rd = 1; dma_rd = 1; cyc();
    chk("R7 no removal while locked", int'(level), 1);
    chk("R7 dma_req low", int'(dma_req), 0);
    err_reset = 1; cyc();
    chk("R8 unlock", int'(locked), 0);
    chk("R8 head restored", int'(head_data), 8'h33);
    err_reset = 1; cyc();
    chk("R8 reset when unlocked", int'(level), 1);

    // overrun on full
    for (int i = 0; i < DEPTH - 1; i++) put(8'h40 + 8'(i), 4'h0);
    chk("R2 full level", int'(level), DEPTH);
    put(8'hAA, 4'h0);
    chk("R5 level stays full", int'(level), DEPTH);
    lock_en = 0;
    for (int i = 0; i < DEPTH - 1; i++) begin cpu_rd = 1; cyc(); end
    chk("R5 newest data", int'(head_data), 8'hAA);
    chk("R5 overrun flag", int'(head_stat), 4'h2);
    cpu_rd = 1; cyc();
    chk("R9 no lock when disabled", int'(locked), 0);
    chk("R10 strobe unlocked mode", int'(spec_taken), 1);

    // write and read together on a full queue
    for (int i = 0; i < DEPTH; i++) put(8'h60 + 8'(i), 4'h0);
    wr_en = 1; wr_data = 8'h77; wr_stat = 4'h0; cpu_rd = 1; cyc();
    chk("R5 write with read on full", int'(level), DEPTH);
    for (int i = 0; i < DEPTH - 1; i++) begin dma_rd = 1; cyc(); end
    chk("R5 no overrun with read", int'(head_stat), 4'h0);
    chk("R2 order", int'(head_data), 8'h77);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      if (n % 250 == 0) lock_en = $urandom_range(0, 1);
      wr_en = ($urandom_range(0, 99) < 50);
      wr_data = 8'($urandom);
      wr_stat = ($urandom_range(0, 99) < 15) ? 4'($urandom_range(1, 15)) : 4'h0;
      cpu_rd = ($urandom_range(0, 99) < 25);
      dma_rd = ($urandom_range(0, 99) < 25);
      err_reset = ($urandom_range(0, 99) < 6);
      cyc();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule